// File: doc/BRIEF.md
# Per-Line RGB Channel Checksum Inserter and Checker

This block sits on a parallel RGB pixel stream of three color channels plus a data-enable qualifier. For every active line it keeps one ones-complement sum per color channel, folding each pixel's channel byte into a running total with end-around carry. When the line ends, the sums can be placed into the stream as one extra word. When the stream already carries such a word, the sums can be compared against it instead.

The stream passes through one register stage. A two-bit mode input picks the behaviour. In pass mode the stream is copied unchanged. In insert mode the cycle that follows the last active pixel carries the three inverted sums, marked by a valid flag. In check mode the incoming word in that same slot is treated as the received checksums, and a per-channel error bit pulses when a channel does not verify.

Top module: `rgbck_line_csum`

## Requirements
- R1: While `rst` is high, and after any clock edge with `rst` high, `out_de`, `out_rgb`, `out_csum_vld` and `err_flags` are all zero.
- R2: Outside the checksum slot, `out_de` and `out_rgb` equal `in_de` and `in_rgb` from one clock earlier.
- R3: Each channel sum adds the channel byte to the running total and feeds any carry out of the top bit back into bit 0. Red is bits 23:16, green is 15:8 and blue is 7:0.
- R4: The inserted word is the bitwise inverse of each channel's final sum, placed in that channel's own byte position.
- R5: In insert mode (`cfg_mode` = 2'b01), the output cycle right after a line's last pixel has `out_csum_vld` = 1, `out_de` = 0 and the checksum word on `out_rgb`. `out_csum_vld` is high for exactly that one cycle.
- R6: The sums restart on each rising edge of `in_de`, so the checksums of a line do not depend on earlier lines.
- R7: In pass mode (`cfg_mode` = 2'b00, and the unused code 2'b11), `out_csum_vld` stays 0 and the stream, including the slot after a line, comes through unchanged with one cycle of delay.
- R8: In check mode (`cfg_mode` = 2'b10), the input word in the cycle after a line's last pixel is the received checksum, and the stream passes unchanged. A bit of `err_flags` (bit 2 red, bit 1 green, bit 0 blue) is 1 for that one output cycle when the end-around sum of the local channel total and the received byte is not all ones. The bit is 0 at every other time.
- R9: A stretch with `in_de` low produces no checksum slot and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 00/11 pass, 01 insert, 10 check |
| in_de | input | 1 | Input data enable (active pixel) |
| in_rgb | input | 24 | Input pixel, red in the top byte |
| out_de | output | 1 | Delayed data enable |
| out_rgb | output | 24 | Delayed pixel or checksum word |
| out_csum_vld | output | 1 | Marks the inserted checksum word |
| err_flags | output | 3 | Per-channel check mismatch pulse |

## Verification
The hardest condition to reach from the ports is a checksum whose channel totals wrap many times, including the case where the stored ones-complement value is all ones. A correct received byte then sums to all ones only through the negative-zero form. The directed tasks drive lines of near-saturated bytes and an all-ones line to reach this case. In check mode they send received words with single-channel and multi-channel corruption masks, so each error bit is shown to separate from the others.

// File: rtl/rgbck_pkg.sv
package rgbck_pkg;

    localparam int unsigned CH_BITS = 8;
    localparam int unsigned CH_COUNT = 3;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'b00,
        MODE_INSERT = 2'b01,
        MODE_CHECK  = 2'b10,
        MODE_SPARE  = 2'b11
    } csum_mode_e;

    typedef struct packed {
        logic insert;
        logic check;
    } mode_ctl_t;

    function automatic mode_ctl_t decode_mode(input csum_mode_e m);
        mode_ctl_t r;
        r.insert = (m == MODE_INSERT);
        r.check  = (m == MODE_CHECK);
        return r;
    endfunction

endpackage

// File: rtl/rgbck_de_edge.sv
module rgbck_de_edge (
    input  logic clk,
    input  logic rst,
    input  logic de,
    output logic rise,
    output logic fall
);
    logic de_q;

    always_ff @(posedge clk) begin
        if (rst) de_q <= 1'b0;
        else     de_q <= de;
    end

    assign rise = de & ~de_q;
    assign fall = ~de & de_q;
endmodule

// File: rtl/rgbck_chan_acc.sv
module rgbck_chan_acc #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pix_en,
    input  logic         restart,
    input  logic [W-1:0] pix,
    input  logic [W-1:0] rx,
    output logic [W-1:0] sum,
    output logic         rx_ok
);
    logic [W-1:0] acc;
    logic [W:0]   raw_pix;
    logic [W:0]   raw_rx;
    logic [W-1:0] next_acc;
    logic [W-1:0] rx_total;

    // end-around carry: carry out of the top bit re-enters at bit 0
    assign raw_pix  = {1'b0, acc} + {1'b0, pix};
    assign next_acc = raw_pix[W-1:0] + {{(W-1){1'b0}}, raw_pix[W]};

    assign raw_rx   = {1'b0, acc} + {1'b0, rx};
    assign rx_total = raw_rx[W-1:0] + {{(W-1){1'b0}}, raw_rx[W]};
    assign rx_ok    = &rx_total;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (pix_en) begin
            acc <= restart ? pix : next_acc;
        end
    end

    assign sum = acc;
endmodule

// File: rtl/rgbck_line_csum.sv
module rgbck_line_csum
    import rgbck_pkg::*;
#(
    parameter int unsigned CH_W = CH_BITS,
    parameter int unsigned N_CH = CH_COUNT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             cfg_mode,
    input  logic                   in_de,
    input  logic [N_CH*CH_W-1:0]   in_rgb,
    output logic                   out_de,
    output logic [N_CH*CH_W-1:0]   out_rgb,
    output logic                   out_csum_vld,
    output logic [N_CH-1:0]        err_flags
);
    localparam int unsigned PIX_W = N_CH * CH_W;

    mode_ctl_t           ctl;
    logic                line_start;
    logic                line_end;
    logic [PIX_W-1:0]    csum_word;
    logic [N_CH-1:0]     chan_ok;
    logic                do_insert;
    logic                do_check;

    assign ctl       = decode_mode(csum_mode_e'(cfg_mode));
    assign do_insert = line_end & ctl.insert;
    assign do_check  = line_end & ctl.check;

    rgbck_de_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .de   (in_de),
        .rise (line_start),
        .fall (line_end)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        logic [CH_W-1:0] chan_sum;

        rgbck_chan_acc #(.W(CH_W)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .pix_en  (in_de),
            .restart (line_start),
            .pix     (in_rgb[c*CH_W +: CH_W]),
            .rx      (in_rgb[c*CH_W +: CH_W]),
            .sum     (chan_sum),
            .rx_ok   (chan_ok[c])
        );

        assign csum_word[c*CH_W +: CH_W] = ~chan_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_de       <= 1'b0;
            out_rgb      <= '0;
            out_csum_vld <= 1'b0;
            err_flags    <= '0;
        end else begin
            out_de       <= in_de;
            out_rgb      <= do_insert ? csum_word : in_rgb;
            out_csum_vld <= do_insert;
            err_flags    <= do_check ? ~chan_ok : '0;
        end
    end
endmodule

// File: rtl/rgbck_line_csum_chk.sv
module rgbck_line_csum_chk
    import rgbck_pkg::*;
#(
    parameter int unsigned CH_W = CH_BITS,
    parameter int unsigned N_CH = CH_COUNT
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           cfg_mode,
    input logic                 in_de,
    input logic [N_CH*CH_W-1:0] in_rgb,
    input logic                 out_de,
    input logic [N_CH*CH_W-1:0] out_rgb,
    input logic                 out_csum_vld,
    input logic [N_CH-1:0]      err_flags
);
    // R5: checksum word never coincides with an active pixel
    p_vld_not_de_r5: assert property (@(posedge clk) disable iff (rst)
        out_csum_vld |-> !out_de);

    // R5: valid lasts one cycle
    p_vld_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        out_csum_vld |=> !out_csum_vld);

    // R9: a checksum word only follows an enable that was high then fell
    p_vld_after_line_r9: assert property (@(posedge clk) disable iff (rst)
        out_csum_vld |-> ($past(in_de, 2) && !$past(in_de)));

    // R5: insertion only in insert mode
    p_vld_mode_r5: assert property (@(posedge clk) disable iff (rst)
        out_csum_vld |-> ($past(cfg_mode) == MODE_INSERT));

    // R2: enable is delayed by one register
    p_de_delay_r2: assert property (@(posedge clk) disable iff (rst)
        !out_csum_vld |-> (out_de == $past(in_de)));

    // R7: pass mode copies the stream
    p_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == MODE_PASS || cfg_mode == MODE_SPARE) |=>
            (!out_csum_vld && out_rgb == $past(in_rgb)));

    // R8: error bits pulse for one cycle
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (|err_flags) |=> (err_flags == '0));

    // R8: errors only in check mode, in the slot after a line
    p_err_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (|err_flags) |-> ($past(cfg_mode) == MODE_CHECK &&
                          $past(in_de, 2) && !$past(in_de)));

    // R1: outputs cleared while reset is held
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_de && !out_csum_vld && out_rgb == '0 && err_flags == '0));
endmodule

bind rgbck_line_csum rgbck_line_csum_chk #(.CH_W(CH_W), .N_CH(N_CH)) u_chk (.*);

// File: tb/rgbck_line_csum_tb.sv
module rgbck_line_csum_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'b00;
    logic        in_de = 1'b0;
    logic [23:0] in_rgb = '0;
    logic        out_de;
    logic [23:0] out_rgb;
    logic        out_csum_vld;
    logic [2:0]  err_flags;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rgbck_line_csum u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_mode     (cfg_mode),
        .in_de        (in_de),
        .in_rgb       (in_rgb),
        .out_de       (out_de),
        .out_rgb      (out_rgb),
        .out_csum_vld (out_csum_vld),
        .err_flags    (err_flags)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // fold a wide total into an 8-bit ones-complement value
    function automatic logic [7:0] fold8(input logic [31:0] t);
        logic [31:0] v = t;
        while (v > 32'hFF) v = (v & 32'hFF) + (v >> 8);
        return v[7:0];
    endfunction

    task automatic run_line(input logic [1:0] mode, input int npix, input logic [23:0] base,
                            input logic [23:0] step, input logic [23:0] corrupt, input string tag);
        logic [31:0] tr = 0, tg = 0, tb = 0;
        logic [23:0] pix, prev, rx, want;
        logic [2:0]  exp_err;
        bit bad = 0;
        cfg_mode = mode;
        prev = '0;
        for (int i = 0; i < npix; i++) begin
            @(negedge clk);
            if (i > 0 && (out_rgb !== prev || out_de !== 1'b1)) bad = 1;
            pix = base + step * i;
            in_de = 1'b1;
            in_rgb = pix;
            tr += pix[23:16]; tg += pix[15:8]; tb += pix[7:0];
            prev = pix;
        end
        want = {~fold8(tr), ~fold8(tg), ~fold8(tb)};
        rx = want ^ corrupt;
        @(negedge clk);
        if (out_rgb !== prev || out_de !== 1'b1) bad = 1;
        in_de = 1'b0;
        in_rgb = rx;
        chk(!bad, {"R2 pixels delayed one cycle ", tag}, {8'h0, out_rgb}, {8'h0, prev});
        @(negedge clk);
        in_rgb = 24'h0;
        if (mode == 2'b01) begin
            chk(out_csum_vld === 1'b1 && out_de === 1'b0, {"R5 slot flags ", tag},
                {30'h0, out_csum_vld, out_de}, 32'h2);
            chk(out_rgb === want, {"R3 R4 checksum word ", tag}, {8'h0, out_rgb}, {8'h0, want});
        end else begin
            chk(out_csum_vld === 1'b0 && out_rgb === rx, {"R7 R8 slot passthrough ", tag},
                {7'h0, out_csum_vld, out_rgb}, {8'h0, rx});
        end
        exp_err[2] = (mode == 2'b10) && (fold8(tr + rx[23:16]) != 8'hFF);
        exp_err[1] = (mode == 2'b10) && (fold8(tg + rx[15:8])  != 8'hFF);
        exp_err[0] = (mode == 2'b10) && (fold8(tb + rx[7:0])   != 8'hFF);
        chk(err_flags === exp_err, {"R8 error bits ", tag}, {29'h0, err_flags}, {29'h0, exp_err});
        @(negedge clk);
        chk(out_csum_vld === 1'b0 && err_flags === 3'b000, {"R5 R8 single-cycle pulse ", tag},
            {28'h0, out_csum_vld, err_flags}, 32'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_de = 1'b1;
        in_rgb = 24'h123456;
        cfg_mode = 2'b01;
        repeat (3) @(negedge clk);
        chk(out_de === 1'b0 && out_rgb === 24'h0 && out_csum_vld === 1'b0 && err_flags === 3'b0,
            "R1 reset state", {4'h0, out_de, out_csum_vld, err_flags, out_rgb}, 32'h0);
        in_de = 1'b0;
        in_rgb = 24'h0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_insert_basic();
        run_line(2'b01, 8, 24'h102030, 24'h010203, 24'h0, "insert ramp");
    endtask

    task automatic t_insert_carry();
        run_line(2'b01, 6, 24'hF0F8FE, 24'h010101, 24'h0, "R3 carry wrap");
        run_line(2'b01, 4, 24'hFFFFFF, 24'h0, 24'h0, "R3 all ones");
    endtask

    task automatic t_single_pixel();
        run_line(2'b01, 1, 24'h5A3C81, 24'h0, 24'h0, "single pixel");
    endtask

    task automatic t_restart();
        run_line(2'b01, 5, 24'hC0C0C0, 24'h111111, 24'h0, "R6 first line");
        run_line(2'b01, 3, 24'h010203, 24'h010101, 24'h0, "R6 second line");
    endtask

    task automatic t_pass();
        run_line(2'b00, 4, 24'hAB12CD, 24'h030201, 24'h0, "R7 mode 00");
        run_line(2'b11, 4, 24'h44556F, 24'h101010, 24'h0, "R7 mode 11");
    endtask

    task automatic t_check();
        run_line(2'b10, 7, 24'h8899AA, 24'h0F0E0D, 24'h0, "R8 good rx");
        run_line(2'b10, 7, 24'h8899AA, 24'h0F0E0D, 24'h004000, "R8 green bad");
        run_line(2'b10, 3, 24'h0A0B0C, 24'h050505, 24'h810001, "R8 red blue bad");
        run_line(2'b10, 2, 24'hFFFFFF, 24'h0, 24'h0, "R8 negative zero");
    endtask

    task automatic t_idle();
        bit seen = 0;
        cfg_mode = 2'b01;
        in_de = 1'b0;
        for (int i = 0; i < 20; i++) begin
            in_rgb = 24'h0F0F0F + 24'(i);
            @(negedge clk);
            if (out_csum_vld !== 1'b0 || err_flags !== 3'b0 || out_de !== 1'b0) seen = 1;
        end
        chk(!seen, "R9 idle produces no slot", {31'h0, seen}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_insert_basic();
        t_insert_carry();
        t_single_pixel();
        t_restart();
        t_pass();
        t_check();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule